// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register File

This block is the processor-facing register file of a two-channel serial controller. A byte-wide bus with chip-select, read and write strobes and a two-bit address reaches a control port and a data port for each channel. Each channel holds sixteen write registers and sixteen read registers. Registers other than register 0 are reached indirectly. A control write made while the channel's pointer is zero loads the pointer. The next control access then targets the selected register, and that access returns the pointer to zero. A point-high command in the same byte lifts the pointer into the upper eight registers.

Besides plain storage, the block carries out the side effects of register accesses. It runs per-channel soft resets and a full hard reset, each with its own keep, set and clear masks per register. It mirrors the baud divisor into the read side. It sets and clears the status bits touched by data-port traffic. It decodes the character format, parity, stop code, clock mode and divisor of each channel onto plain outputs for the bit engine, which lives elsewhere. Received bytes come in on a valid/ready port per channel. A byte is accepted only while the receiver is enabled and the previous byte has been read. Transmit bytes leave on a one-cycle valid strobe per channel. That strobe has no ready: the consumer must take every byte it is offered.

Channel index 0 is channel A and index 1 is channel B. All multi-channel outputs are packed with channel A in the low slice.

Top module: `dual_serial_regs`

## Requirements
- R1: After `rst_n` low, every register of both channels is zero except read register 0, which is 0x04 (tx-empty). Both pointers are zero, `rx_ready` and `tx_valid` are 0, and every format output shows code zero.
- R2: With `addr_swap`=0, `addr[0]` selects the port (0 control, 1 data) and `addr[1]` selects the channel (0 A, 1 B). With `addr_swap`=1 the two address bits exchange roles.
- R3: A control write while the pointer is 0 loads the pointer from `wdata[2:0]`. If `wdata[5:3]` is 3'b001, 8 is added, so registers 8 to 15 can be reached.
- R4: A control access (read or write) with a non-zero pointer returns the pointer to 0, as does any control read. A control read places the selected read register on `rdata` from the next cycle. `rdata` changes only on a read (`cs`, `rd` high, `wr` low).
- R5: Writes to registers 12 (low) and 13 (high) set the 16-bit `baud_div` and read back through read registers 12 and 13. Register 4 bits 7:6 give `clk_shift` as log2 of the clock mode: 00→0, 01→4, 10→5, 11→6. Format outputs change only after bus writes.
- R6: Writing register 3 with bit 4 set sets bit 4 (sync) of read register 0. Writing register 4 sets bit 0 (all-sent) of read register 1.
- R7: A data-port write sets bit 2 of read register 0 and bit 0 of read register 1. If register 5 bit 3 is set, `tx_valid` for that channel is high for exactly the next cycle with the byte on `tx_data`. Otherwise no strobe is issued.
- R8: `rx_ready` is register 3 bit 0 AND NOT read register 0 bit 0. An accepted byte is stored and sets read register 0 bit 0; bytes offered while not ready are dropped. A data-port read returns the stored byte (also readable as read register 8) and clears bit 0.
- R9: Writing register 9 of either channel with bits 7:6 = 01 soft-resets channel B, and 10 soft-resets channel A. The other channel's registers are left unchanged. With bits 7:6 = 00 the value is stored.
- R10: A soft reset sets read register 0 to (old AND 0xB8) OR 0x44 and read register 1 to (old AND 0x01) OR 0x06, and clears the received byte. It clears register 3 bit 0 and sets register 4 bit 2. It keeps only bits 6:5 and 0 of register 5 (dropping transmit enable, bit 3). It sets register 14 to (old AND 0xC3) OR 0x20, so loopback (bit 4) clears. It loads register 15 with 0xF8 and masks registers 1, 9 and 10.
- R11: Bits 7:6 = 11 in register 9 hard-resets both channels. This is soft reset plus register 9 = (old AND 0x03) OR 0xC0, register 10 = 0, register 11 = 0x08, and register 14 = (old AND 0xC0) OR 0x30, so `loopback` is set in both channels.
- R12: Register 5 bits 6:5 give `char_bits`: 00→5, 01→7, 10→6, 11→8. Register 4 bit 0 drives `par_en`, bit 1 drives `par_even`, and bits 3:2 appear on `stop_sel`. Register 14 bit 4 drives `loopback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_swap | input | 1 | Exchanges the roles of the two address bits |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Port and channel select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_valid | input | 2 | Received byte offered, per channel |
| rx_data | input | 16 | Received bytes, A in [7:0] |
| rx_ready | output | 2 | Channel can take a byte |
| tx_valid | output | 2 | One-cycle transmit strobe per channel |
| tx_data | output | 16 | Transmit bytes, A in [7:0] |
| baud_div | output | 32 | Baud divisor per channel |
| clk_shift | output | 6 | log2 of clock mode per channel |
| char_bits | output | 8 | Character length per channel |
| par_en | output | 2 | Parity enable per channel |
| par_even | output | 2 | Even parity per channel |
| stop_sel | output | 4 | Stop code per channel |
| loopback | output | 2 | Local loopback per channel |

## Verification
The hardest state to reach from the ports is a soft reset that lands while a channel holds a mix of set bits that must partly survive. That mix is a pending received byte, the sync flag, the all-sent flag, a half-set stop code, transmit enable and loopback. The reset must also be triggered through the other channel's register 9, so that cross-channel isolation is visible. The stimulus builds that state with directed accesses and then checks every port-visible consequence. A seeded random phase interleaves pointer writes, format writes, swapped addressing, byte offers and data reads. It compares each format output and `rx_ready` against a bench model after every step.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 16;
  localparam int PW     = $clog2(NREG);
  localparam int NCH    = 2;
  localparam int DIVW   = 2 * DW;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  // write register indices whose side effects matter
  localparam logic [PW-1:0] RI_RXC  = 4'd3;
  localparam logic [PW-1:0] RI_FMT  = 4'd4;
  localparam logic [PW-1:0] RI_TXC  = 4'd5;
  localparam logic [PW-1:0] RI_RST  = 4'd9;
  localparam logic [PW-1:0] RI_MSC  = 4'd10;
  localparam logic [PW-1:0] RI_CKS  = 4'd11;
  localparam logic [PW-1:0] RI_DVL  = 4'd12;
  localparam logic [PW-1:0] RI_DVH  = 4'd13;
  localparam logic [PW-1:0] RI_AUX  = 4'd14;
  localparam logic [PW-1:0] RI_EXT  = 4'd15;
  localparam logic [PW-1:0] RI_MSK1 = 4'd1;

  // read register indices
  localparam logic [PW-1:0] RR_STAT = 4'd0;
  localparam logic [PW-1:0] RR_SPEC = 4'd1;
  localparam logic [PW-1:0] RR_RXB  = 4'd8;

  localparam logic [2:0] CMD_UPPER = 3'd1;

  typedef enum logic [1:0] {
    RQ_NONE = 2'b00,
    RQ_CHB  = 2'b01,
    RQ_CHA  = 2'b10,
    RQ_ALL  = 2'b11
  } rst_rq_e;

  // reset masks
  localparam logic [DW-1:0] ST_KEEP   = 8'hB8;
  localparam logic [DW-1:0] ST_SET    = 8'h44;
  localparam logic [DW-1:0] ST_POWER  = 8'h04;
  localparam logic [DW-1:0] SP_KEEP   = 8'h01;
  localparam logic [DW-1:0] SP_SET    = 8'h06;
  localparam logic [DW-1:0] M1_KEEP   = 8'h24;
  localparam logic [DW-1:0] TX_KEEP   = 8'h61;
  localparam logic [DW-1:0] R9_SOFT   = 8'hDF;
  localparam logic [DW-1:0] R9_HKEEP  = 8'h03;
  localparam logic [DW-1:0] R9_HSET   = 8'hC0;
  localparam logic [DW-1:0] MS_KEEP   = 8'h60;
  localparam logic [DW-1:0] CK_HARD   = 8'h08;
  localparam logic [DW-1:0] AX_SKEEP  = 8'hC3;
  localparam logic [DW-1:0] AX_SSET   = 8'h20;
  localparam logic [DW-1:0] AX_HKEEP  = 8'hC0;
  localparam logic [DW-1:0] AX_HSET   = 8'h30;
  localparam logic [DW-1:0] EX_SET    = 8'hF8;
endpackage

// File: rtl/dsr_port_decode.sv
module dsr_port_decode (
  input  logic       swap,
  input  logic [1:0] addr,
  output logic       is_data,
  output logic       ch_sel
);
  always_comb begin
    if (swap) begin
      is_data = addr[1];
      ch_sel  = addr[0];
    end else begin
      is_data = addr[0];
      ch_sel  = addr[1];
    end
  end
endmodule

// File: rtl/dsr_fmt.sv
module dsr_fmt
  import dsr_pkg::*;
(
  input  logic [1:0]      mode_code,
  input  logic [1:0]      len_code,
  output logic [2:0]      shift,
  output logic [3:0]      bits
);
  always_comb begin
    unique case (mode_code)
      2'b00:   shift = 3'd0;
      2'b01:   shift = 3'd4;
      2'b10:   shift = 3'd5;
      default: shift = 3'd6;
    endcase
    unique case (len_code)
      2'b00:   bits = 4'd5;
      2'b01:   bits = 4'd7;
      2'b10:   bits = 4'd6;
      default: bits = 4'd8;
    endcase
  end
endmodule

// File: rtl/dsr_channel.sv
module dsr_channel
  import dsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic          soft_rst,
  input  logic          hard_rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rd_byte,
  output logic [1:0]    rst_rq,
  output logic [1:0]    cfg_mode,
  output logic [1:0]    cfg_stop,
  output logic [1:0]    cfg_par,
  output logic [1:0]    cfg_len,
  output logic [DIVW-1:0] cfg_div,
  output logic          cfg_loop
);
  logic [DW-1:0] wreg [NREG];
  logic [DW-1:0] st_q, sp_q, rxb_q;
  logic [PW-1:0] ptr_q;

  assign rx_ready = wreg[RI_RXC][0] && !st_q[0];
  assign rst_rq   = (ctl_wr && ptr_q == RI_RST) ? wdata[7:6] : RQ_NONE;

  always_comb begin
    if (dat_rd) rd_byte = rxb_q;
    else begin
      unique case (ptr_q)
        RR_STAT: rd_byte = st_q;
        RR_SPEC: rd_byte = sp_q;
        RR_RXB:  rd_byte = rxb_q;
        RI_DVL:  rd_byte = wreg[RI_DVL];
        RI_DVH:  rd_byte = wreg[RI_DVH];
        default: rd_byte = '0;
      endcase
    end
  end

  assign cfg_mode = wreg[RI_FMT][7:6];
  assign cfg_stop = wreg[RI_FMT][3:2];
  assign cfg_par  = wreg[RI_FMT][1:0];
  assign cfg_len  = wreg[RI_TXC][6:5];
  assign cfg_div  = {wreg[RI_DVH], wreg[RI_DVL]};
  assign cfg_loop = wreg[RI_AUX][4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wreg[i] <= '0;
      st_q     <= ST_POWER;
      sp_q     <= '0;
      rxb_q    <= '0;
      ptr_q    <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (ctl_wr) begin
        if (ptr_q == '0) begin
          ptr_q <= {(wdata[5:3] == CMD_UPPER), wdata[2:0]};
        end else begin
          ptr_q <= '0;
          unique case (ptr_q)
            RI_RST: if (wdata[7:6] == RQ_NONE) wreg[RI_RST] <= wdata;
            RI_RXC: begin
              wreg[RI_RXC] <= wdata;
              if (wdata[4]) st_q[4] <= 1'b1;
            end
            RI_FMT: begin
              wreg[RI_FMT] <= wdata;
              sp_q[0]      <= 1'b1;
            end
            default: wreg[ptr_q] <= wdata;
          endcase
        end
      end
      if (ctl_rd) ptr_q <= '0;
      if (dat_wr) begin
        st_q[2] <= 1'b1;
        sp_q[0] <= 1'b1;
        if (wreg[RI_TXC][3]) begin
          tx_valid <= 1'b1;
          tx_byte  <= wdata;
        end
      end
      if (dat_rd) st_q[0] <= 1'b0;
      if (rx_valid && rx_ready) begin
        rxb_q   <= rx_byte;
        st_q[0] <= 1'b1;
      end
      if (soft_rst || hard_rst) begin
        ptr_q         <= '0;
        st_q          <= (st_q & ST_KEEP) | ST_SET;
        sp_q          <= (sp_q & SP_KEEP) | SP_SET;
        rxb_q         <= '0;
        wreg[RI_MSK1] <= wreg[RI_MSK1] & M1_KEEP;
        wreg[RI_RXC]  <= {wreg[RI_RXC][7:1], 1'b0};
        wreg[RI_FMT]  <= wreg[RI_FMT] | 8'h04;
        wreg[RI_TXC]  <= wreg[RI_TXC] & TX_KEEP;
        wreg[RI_EXT]  <= EX_SET;
        if (hard_rst) begin
          wreg[RI_RST] <= (wreg[RI_RST] & R9_HKEEP) | R9_HSET;
          wreg[RI_MSC] <= '0;
          wreg[RI_CKS] <= CK_HARD;
          wreg[RI_AUX] <= (wreg[RI_AUX] & AX_HKEEP) | AX_HSET;
        end else begin
          wreg[RI_RST] <= wreg[RI_RST] & R9_SOFT;
          wreg[RI_MSC] <= wreg[RI_MSC] & MS_KEEP;
          wreg[RI_AUX] <= (wreg[RI_AUX] & AX_SKEEP) | AX_SSET;
        end
      end
    end
  end
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs
  import dsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_swap,
  input  logic                cs,
  input  logic                rd,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic [NCH-1:0]      rx_valid,
  input  logic [NCH*DW-1:0]   rx_data,
  output logic [NCH-1:0]      rx_ready,
  output logic [NCH-1:0]      tx_valid,
  output logic [NCH*DW-1:0]   tx_data,
  output logic [NCH*DIVW-1:0] baud_div,
  output logic [NCH*3-1:0]    clk_shift,
  output logic [NCH*4-1:0]    char_bits,
  output logic [NCH-1:0]      par_en,
  output logic [NCH-1:0]      par_even,
  output logic [NCH*2-1:0]    stop_sel,
  output logic [NCH-1:0]      loopback
);
  logic          is_data, ch_sel;
  logic          rd_en, wr_en;
  logic [DW-1:0] rd_byte [NCH];
  logic [1:0]    rq     [NCH];
  logic          hard_rst;
  logic [NCH-1:0] soft_rst;

  dsr_port_decode u_dec (
    .swap(addr_swap), .addr(addr), .is_data(is_data), .ch_sel(ch_sel)
  );

  assign rd_en    = cs && rd && !wr;
  assign wr_en    = cs && wr;
  assign hard_rst = (rq[CH_A] == RQ_ALL) || (rq[CH_B] == RQ_ALL);
  assign soft_rst[CH_A] = (rq[CH_A] == RQ_CHA) || (rq[CH_B] == RQ_CHA);
  assign soft_rst[CH_B] = (rq[CH_A] == RQ_CHB) || (rq[CH_B] == RQ_CHB);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       here;
    logic [1:0] mode_c, par_c, len_c;
    assign here = (ch_sel == c[0]);

    dsr_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(wr_en && here && !is_data),
      .ctl_rd(rd_en && here && !is_data),
      .dat_wr(wr_en && here && is_data),
      .dat_rd(rd_en && here && is_data),
      .wdata(wdata),
      .soft_rst(soft_rst[c]), .hard_rst(hard_rst),
      .rx_valid(rx_valid[c]), .rx_byte(rx_data[c*DW +: DW]),
      .rx_ready(rx_ready[c]),
      .tx_valid(tx_valid[c]), .tx_byte(tx_data[c*DW +: DW]),
      .rd_byte(rd_byte[c]), .rst_rq(rq[c]),
      .cfg_mode(mode_c), .cfg_stop(stop_sel[c*2 +: 2]),
      .cfg_par(par_c), .cfg_len(len_c),
      .cfg_div(baud_div[c*DIVW +: DIVW]),
      .cfg_loop(loopback[c])
    );

    dsr_fmt u_fmt (
      .mode_code(mode_c), .len_code(len_c),
      .shift(clk_shift[c*3 +: 3]), .bits(char_bits[c*4 +: 4])
    );

    assign par_en[c]   = par_c[0];
    assign par_even[c] = par_c[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_byte[ch_sel];
  end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        rd,
  input logic        wr,
  input logic [7:0]  rdata,
  input logic [1:0]  rx_valid,
  input logic [1:0]  rx_ready,
  input logic [1:0]  tx_valid,
  input logic [31:0] baud_div,
  input logic [7:0]  char_bits,
  input logic [1:0]  loopback
);
  // R4: read data only moves on a read access
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd && !wr) |=> $stable(rdata));

  // R5, R12: format state moves only after a bus write
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr) |=> ($stable(baud_div) && $stable(char_bits) && $stable(loopback)));

  // R7: one channel strobes at a time
  p_tx_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid));

  // R7: a strobe follows a write
  p_tx_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_valid) |-> $past(cs && wr));

  for (genvar c = 0; c < 2; c++) begin : g_rx
    // R8: an accepted byte closes the port until it is read
    p_rx_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[c] && rx_ready[c]) |=> !rx_ready[c]);
  end
endmodule

bind dual_serial_regs dsr_checker i_dsr_checker (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .rdata(rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .baud_div(baud_div), .char_bits(char_bits), .loopback(loopback)
);

// File: tb/test_dual_serial_regs.sv
module test_dual_serial_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_swap = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_ready, tx_valid;
  logic [15:0] tx_data;
  logic [31:0] baud_div;
  logic [5:0]  clk_shift;
  logic [7:0]  char_bits;
  logic [1:0]  par_en, par_even, loopback;
  logic [3:0]  stop_sel;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_w   [2][16];
  logic [7:0] m_st  [2];
  logic [7:0] m_sp  [2];
  logic [7:0] m_rxb [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_serial_regs i_dual_serial_regs (
    .clk(clk), .rst_n(rst_n), .addr_swap(addr_swap), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .baud_div(baud_div), .clk_shift(clk_shift), .char_bits(char_bits),
    .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel), .loopback(loopback)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] f_bits(input logic [7:0] w5);
    case (w5[6:5]) 2'b00: return 4'd5; 2'b01: return 4'd7; 2'b10: return 4'd6; default: return 4'd8; endcase
  endfunction

  function automatic logic [2:0] f_shift(input logic [7:0] w4);
    case (w4[7:6]) 2'b00: return 3'd0; 2'b01: return 3'd4; 2'b10: return 3'd5; default: return 3'd6; endcase
  endfunction

  task automatic m_soft(input int c);
    m_st[c] = (m_st[c] & 8'hB8) | 8'h44;
    m_sp[c] = (m_sp[c] & 8'h01) | 8'h06;
    m_rxb[c] = 8'h00;
    m_w[c][1]  &= 8'h24;
    m_w[c][3]  &= 8'hFE;
    m_w[c][4]  |= 8'h04;
    m_w[c][5]  &= 8'h61;
    m_w[c][9]  &= 8'hDF;
    m_w[c][10] &= 8'h60;
    m_w[c][14] = (m_w[c][14] & 8'hC3) | 8'h20;
    m_w[c][15] = 8'hF8;
  endtask

  task automatic m_hard();
    for (int c = 0; c < 2; c++) begin
      m_soft(c);
      m_w[c][9]  = (m_w[c][9] & 8'h03) | 8'hC0;
      m_w[c][10] = 8'h00;
      m_w[c][11] = 8'h08;
      m_w[c][14] = (m_w[c][14] & 8'hC0) | 8'h30;
    end
  endtask

  // one bus cycle, driven at the falling edge; returns at the next falling edge
  task automatic acc(input bit is_wr, input bit dport, input int c, input logic [7:0] d);
    addr  = addr_swap ? {dport, c[0]} : {c[0], dport};
    cs    = 1'b1;
    wr    = is_wr;
    rd    = !is_wr;
    wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic point(input int c, input int r);
    if (r >= 8) acc(1, 0, c, {2'b00, 3'b001, r[2:0]});
    else if (r > 0) acc(1, 0, c, {5'b0, r[2:0]});
  endtask

  task automatic wr_reg(input int c, input int r, input logic [7:0] v);
    point(c, r);
    acc(1, 0, c, v);
    case (r)
      3: begin m_w[c][3] = v; if (v[4]) m_st[c][4] = 1'b1; end
      4: begin m_w[c][4] = v; m_sp[c][0] = 1'b1; end
      9: case (v[7:6])
           2'b00: m_w[c][9] = v;
           2'b01: m_soft(1);
           2'b10: m_soft(0);
           default: m_hard();
         endcase
      default: m_w[c][r] = v;
    endcase
  endtask

  task automatic rd_reg(input int c, input int r, output logic [7:0] v);
    point(c, r);
    acc(0, 0, c, 8'h00);
    v = rdata;
  endtask

  task automatic dwrite(input int c, input logic [7:0] v);
    acc(1, 1, c, v);
    m_st[c][2] = 1'b1;
    m_sp[c][0] = 1'b1;
  endtask

  task automatic dread(input int c, output logic [7:0] v);
    acc(0, 1, c, 8'h00);
    v = rdata;
    m_st[c][0] = 1'b0;
  endtask

  task automatic rx_push(input int c, input logic [7:0] v);
    bit take;
    take = m_w[c][3][0] && !m_st[c][0];
    rx_valid[c] = 1'b1;
    rx_data[c*8 +: 8] = v;
    @(posedge clk);
    @(negedge clk);
    rx_valid = '0;
    if (take) begin m_rxb[c] = v; m_st[c][0] = 1'b1; end
  endtask

  task automatic chk_fmt(input string tag, input int c);
    chk({tag, " baud_div"}, baud_div[c*16 +: 16], {m_w[c][13], m_w[c][12]});
    chk({tag, " clk_shift"}, clk_shift[c*3 +: 3], f_shift(m_w[c][4]));
    chk({tag, " char_bits"}, char_bits[c*4 +: 4], f_bits(m_w[c][5]));
    chk({tag, " par"}, {par_even[c], par_en[c]}, m_w[c][4][1:0]);
    chk({tag, " stop"}, stop_sel[c*2 +: 2], m_w[c][4][3:2]);
    chk({tag, " loop"}, loopback[c], m_w[c][14][4]);
    chk({tag, " rx_ready"}, rx_ready[c], m_w[c][3][0] && !m_st[c][0]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 16; r++) m_w[c][r] = 8'h00;
      m_st[c] = 8'h04; m_sp[c] = 8'h00; m_rxb[c] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: power-up state
    for (int c = 0; c < 2; c++) begin
      chk_fmt("R1 reset", c);
      rd_reg(c, 0, v); chk("R1 status", v, 8'h04);
      rd_reg(c, 1, v); chk("R1 spec", v, 8'h00);
    end
    chk("R1 tx_valid", tx_valid, 2'b00);

    // R3: point-high reaches register 13; R5 mirror
    wr_reg(0, 13, 8'hBE);
    chk("R3 upper pointer", baud_div[15:8], 8'hBE);
    wr_reg(0, 12, 8'h5A);
    rd_reg(0, 12, v); chk("R5 mirror low", v, 8'h5A);
    rd_reg(0, 13, v); chk("R5 mirror high", v, 8'hBE);
    // R4: pointer cleared after the read, next control read sees register 0
    acc(0, 0, 0, 8'h00); chk("R4 ptr back to 0", rdata, m_st[0]);
    // R4: write path clears too
    wr_reg(0, 2, 8'h11);
    acc(0, 0, 0, 8'h00); chk("R4 ptr after write", rdata, m_st[0]);

    // R2: channel B with and without swap
    wr_reg(1, 12, 8'hA5);
    chk("R2 chB plain", baud_div[31:16], 16'h00A5);
    chk("R2 chA untouched", baud_div[15:0], 16'hBE5A);
    addr_swap = 1'b1;
    wr_reg(1, 12, 8'h3C);
    chk("R2 chB swapped", baud_div[31:16], 16'h003C);
    chk("R2 chA after swap", baud_div[15:0], 16'hBE5A);
    addr_swap = 1'b0;

    // R5 clock mode, R12 length and parity
    for (int k = 0; k < 4; k++) begin
      wr_reg(0, 4, {k[1:0], 4'b0000, k[1:0]});
      chk_fmt("R5 R12 fmt4", 0);
      wr_reg(0, 5, {1'b0, k[1:0], 5'b0});
      chk_fmt("R12 len", 0);
    end

    // R6: hunt sets sync, register 4 write sets all-sent
    wr_reg(1, 3, 8'h10);
    rd_reg(1, 0, v); chk("R6 sync", v, 8'h14);
    wr_reg(1, 4, 8'h00);
    rd_reg(1, 1, v); chk("R6 all-sent", v, 8'h01);

    // R7: transmit gated by enable
    dwrite(1, 8'h42);
    chk("R7 no strobe", tx_valid, 2'b00);
    wr_reg(1, 5, 8'h08);
    dwrite(1, 8'h9D);
    chk("R7 strobe", tx_valid, 2'b10);
    chk("R7 data", tx_data[15:8], 8'h9D);
    @(negedge clk);
    chk("R7 one cycle", tx_valid, 2'b00);
    rd_reg(1, 0, v); chk("R7 status", v, m_st[1]);

    // R8: receive handshake
    rx_push(0, 8'h77);
    chk("R8 disabled drop", rx_ready[0], 1'b0);
    rd_reg(0, 0, v); chk("R8 no avail", v[0], 1'b0);
    wr_reg(0, 3, 8'h01);
    chk("R8 ready", rx_ready[0], 1'b1);
    rx_push(0, 8'hC3);
    chk("R8 full", rx_ready[0], 1'b0);
    rx_push(0, 8'h12);
    rd_reg(0, 8, v); chk("R8 byte kept", v, 8'hC3);
    dread(0, v); chk("R8 data read", v, 8'hC3);
    chk("R8 ready again", rx_ready[0], 1'b1);

    // R9 / R10: soft reset of A requested through B
    wr_reg(0, 3, 8'h11);
    rx_push(0, 8'h3C);
    wr_reg(0, 4, 8'h08);
    wr_reg(0, 5, 8'h68);
    wr_reg(0, 14, 8'h10);
    wr_reg(1, 12, 8'h77);
    chk("R12 loopback", loopback[0], 1'b1);
    wr_reg(1, 9, 8'h80);
    rd_reg(0, 0, v); chk("R10 status", v, 8'h54);
    rd_reg(0, 1, v); chk("R10 spec", v, 8'h07);
    rd_reg(0, 8, v); chk("R10 rx cleared", v, 8'h00);
    chk("R10 stop code", stop_sel[1:0], 2'b11);
    chk_fmt("R10 chA", 0);
    chk_fmt("R9 chB kept", 1);
    chk("R9 chB div", baud_div[23:16], 8'h77);
    dwrite(0, 8'h55); chk("R10 tx disabled", tx_valid, 2'b00);
    wr_reg(0, 9, 8'h40);
    rd_reg(1, 1, v); chk("R9 soft B spec", v, m_sp[1]);
    chk_fmt("R9 soft B", 1);

    // R11: hard reset
    wr_reg(0, 9, 8'hC0);
    chk("R11 loopback", loopback, 2'b11);
    for (int c = 0; c < 2; c++) begin
      chk_fmt("R11 fmt", c);
      rd_reg(c, 0, v); chk("R11 status", v, m_st[c]);
      rd_reg(c, 1, v); chk("R11 spec", v, m_sp[c]);
    end

    // random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 400; i++) begin
      int c, op;
      logic [7:0] d;
      c  = int'($urandom % 2);
      op = int'($urandom % 8);
      d  = 8'($urandom);
      addr_swap = 1'($urandom);
      case (op)
        0: wr_reg(c, 4, d);
        1: wr_reg(c, 5, d & 8'hF7);
        2: wr_reg(c, 12, d);
        3: wr_reg(c, 13, d);
        4: wr_reg(c, 3, d);
        5: rx_push(c, d);
        6: begin
             logic exp_b;
             exp_b = m_st[c][0];
             dread(c, v);
             if (exp_b) chk("R8 random read", v, m_rxb[c]);
           end
        default: begin
             rd_reg(c, 0, v); chk("R6 R8 random status", v, m_st[c]);
           end
      endcase
      chk_fmt("R5 R12 random A", 0);
      chk_fmt("R5 R12 random B", 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule